// File: doc/BRIEF.md
# Test Wrapper Boundary Cell

This block is one boundary cell of a core test wrapper. It sits on a single functional terminal of an embedded core, which may be one bit or a small bus. It is chained with its neighbours through a serial test input and test output to form the wrapper's boundary register. Each cell has two storage stages. A shift stage moves test data along the chain and can also sample the functional value. An update stage holds the value the cell drives during test. A 2-bit mode input, decoded elsewhere from the wrapper instruction, sets what reaches the functional output:
- the functional input unchanged;
- test data aimed at the core;
- test data aimed at the logic around the core;
- a fixed safe pattern.

The shift, capture, update and apply events are kept separate. Shifting and capturing only change the shift stage. The driven value changes only when an update moves new data into the update stage, and that data is applied through the mode multiplexer. A parameter states whether the cell sits on a core input or a core output. In inward-facing mode, a cell on a core input drives its update stage towards the core. In outward-facing mode, a cell on a core output drives its update stage towards the system logic. In the other facing mode the cell lets the functional value through and observes it. In both placements, capture samples the functional input: on an input cell this is the chip-side value, and on an output cell it is the value coming from the core.

Top module: `wbc_cell`

## Requirements
- R1: While reset is active (rst_n low, asynchronous), the shift stage is cleared, so test_out is 0, and the update stage holds SAFE_VAL. Both stages stay that way until reset is released.
- R2: With mode 2'b00 (normal), func_out equals func_in combinationally, whatever the stages hold.
- R3: With mode 2'b01 (inward-facing), a cell with ON_CORE_INPUT=1 drives func_out from the update stage. A cell with ON_CORE_INPUT=0 passes func_in to func_out.
- R4: With mode 2'b10 (outward-facing), the roles in R3 are swapped. A cell with ON_CORE_INPUT=0 drives func_out from the update stage, and a cell with ON_CORE_INPUT=1 passes func_in.
- R5: With mode 2'b11 (safe), func_out equals SAFE_VAL, whatever func_in and the update stage hold.
- R6: On a rising clk edge with shift_en high, the shift stage moves one place towards its MSB. test_in enters bit 0, and test_out always shows the MSB, so the first bit shifted in is the first to leave a full-width cell.
- R7: On a rising clk edge with capture_en high and shift_en low, the shift stage loads func_in. When both are high, the shift wins and nothing is captured.
- R8: On a rising clk edge with update_en high and shift_en low, the update stage loads the shift stage. With shift_en high, update_en has no effect.
- R9: Shift and capture operations never change func_out. A new test value reaches func_out only through an update.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Wrapper test clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode | input | 2 | 00 normal, 01 inward-facing, 10 outward-facing, 11 safe |
| shift_en | input | 1 | Shift the chain one place per edge |
| capture_en | input | 1 | Load func_in into the shift stage |
| update_en | input | 1 | Copy the shift stage into the update stage |
| test_in | input | 1 | Serial data from the previous cell |
| test_out | output | 1 | Serial data to the next cell (shift stage MSB) |
| func_in | input | WIDTH | Functional value arriving at the cell |
| func_out | output | WIDTH | Functional value driven out of the cell |

## Verification
A wrong shift stage cannot be seen at func_out. It shows on test_out one edge later, or after WIDTH further shifts once the corrupted bit has moved up to the MSB, so the bench checks every serial bit it reads back. A corrupted update stage shows at func_out in the driving facing mode and in no other mode. It therefore only appears once the bench selects that mode after an update. An update that leaks during a shift changes the driven value on the same edge, which is why func_out is checked after every shift pulse.

// File: rtl/wbc_pkg.sv
package wbc_pkg;

  typedef enum logic [1:0] {
    WBC_NORMAL  = 2'b00,
    WBC_INWARD  = 2'b01,
    WBC_OUTWARD = 2'b10,
    WBC_SAFE    = 2'b11
  } wbc_mode_e;

  // True when the cell drives its update stage onto the functional output.
  function automatic logic wbc_drives_test(input logic [1:0] mode, input bit on_core_input);
    return ((mode == WBC_INWARD) && on_core_input) ||
           ((mode == WBC_OUTWARD) && !on_core_input);
  endfunction

  // Event qualification: shift takes priority over capture and update.
  function automatic logic wbc_gate_by_shift(input logic en, input logic shift);
    return en && !shift;
  endfunction

endpackage

// File: rtl/wbc_shift_stage.sv
module wbc_shift_stage #(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             do_shift,
  input  logic             do_capture,
  input  logic             ser_in,
  input  logic [WIDTH-1:0] par_in,
  output logic [WIDTH-1:0] q,
  output logic             ser_out
);

  logic [WIDTH-1:0] shifted;

  generate
    if (WIDTH == 1) begin : g_single
      assign shifted = ser_in;
    end else begin : g_multi
      assign shifted = {q[WIDTH-2:0], ser_in};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          q <= '0;
    else if (do_shift)   q <= shifted;
    else if (do_capture) q <= par_in;
  end

  assign ser_out = q[WIDTH-1];

endmodule

// File: rtl/wbc_update_stage.sv
module wbc_update_stage #(
  parameter int               WIDTH    = 4,
  parameter logic [WIDTH-1:0] SAFE_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= SAFE_VAL;
    else if (load) q <= d;
  end

endmodule

// File: rtl/wbc_mode_mux.sv
module wbc_mode_mux
  import wbc_pkg::*;
#(
  parameter int               WIDTH         = 4,
  parameter logic [WIDTH-1:0] SAFE_VAL      = '0,
  parameter bit               ON_CORE_INPUT = 1'b1
) (
  input  logic [1:0]       mode,
  input  logic [WIDTH-1:0] func_in,
  input  logic [WIDTH-1:0] upd_q,
  output logic [WIDTH-1:0] func_out,
  output logic             apply_test
);

  assign apply_test = wbc_drives_test(mode, ON_CORE_INPUT);

  always_comb begin
    if (mode == WBC_SAFE) func_out = SAFE_VAL;
    else if (apply_test)  func_out = upd_q;
    else                  func_out = func_in;
  end

endmodule

// File: rtl/wbc_cell.sv
module wbc_cell
  import wbc_pkg::*;
#(
  parameter int               WIDTH         = 4,
  parameter logic [WIDTH-1:0] SAFE_VAL      = '0,
  parameter bit               ON_CORE_INPUT = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       mode,
  input  logic             shift_en,
  input  logic             capture_en,
  input  logic             update_en,
  input  logic             test_in,
  output logic             test_out,
  input  logic [WIDTH-1:0] func_in,
  output logic [WIDTH-1:0] func_out
);

  // Named internal events, visible to the bound checker.
  logic             ev_shift;
  logic             ev_capture;
  logic             ev_update;
  logic             ev_apply;
  logic [WIDTH-1:0] shf_q;
  logic [WIDTH-1:0] upd_q;

  assign ev_shift   = shift_en;
  assign ev_capture = wbc_gate_by_shift(capture_en, shift_en);
  assign ev_update  = wbc_gate_by_shift(update_en, shift_en);

  wbc_shift_stage #(.WIDTH(WIDTH)) u_shift (
    .clk        (clk),
    .rst_n      (rst_n),
    .do_shift   (ev_shift),
    .do_capture (ev_capture),
    .ser_in     (test_in),
    .par_in     (func_in),
    .q          (shf_q),
    .ser_out    (test_out)
  );

  wbc_update_stage #(.WIDTH(WIDTH), .SAFE_VAL(SAFE_VAL)) u_update (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (ev_update),
    .d     (shf_q),
    .q     (upd_q)
  );

  wbc_mode_mux #(.WIDTH(WIDTH), .SAFE_VAL(SAFE_VAL), .ON_CORE_INPUT(ON_CORE_INPUT)) u_mux (
    .mode       (mode),
    .func_in    (func_in),
    .upd_q      (upd_q),
    .func_out   (func_out),
    .apply_test (ev_apply)
  );

endmodule

// File: rtl/wbc_cell_chk.sv
module wbc_cell_chk #(
  parameter int               WIDTH         = 4,
  parameter logic [WIDTH-1:0] SAFE_VAL      = '0,
  parameter bit               ON_CORE_INPUT = 1'b1
) (
  input logic             clk,
  input logic             rst_n,
  input logic [1:0]       mode,
  input logic             shift_en,
  input logic             capture_en,
  input logic             update_en,
  input logic             test_in,
  input logic             test_out,
  input logic [WIDTH-1:0] func_in,
  input logic [WIDTH-1:0] func_out,
  input logic [WIDTH-1:0] shf_q,
  input logic [WIDTH-1:0] upd_q
);

  AST_RESET_SERIAL_LOW: assert property (@(posedge clk) !rst_n |-> !test_out); // R1

  AST_NORMAL_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    mode == 2'b00 |-> func_out == func_in); // R2

  AST_INWARD_ROUTE: assert property (@(posedge clk) disable iff (!rst_n)
    mode == 2'b01 |-> func_out == (ON_CORE_INPUT ? upd_q : func_in)); // R3

  AST_OUTWARD_ROUTE: assert property (@(posedge clk) disable iff (!rst_n)
    mode == 2'b10 |-> func_out == (ON_CORE_INPUT ? func_in : upd_q)); // R4

  AST_SAFE_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    mode == 2'b11 |-> func_out == SAFE_VAL); // R5

  AST_SHIFT_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    shift_en |=> shf_q[0] == $past(test_in)); // R6

  AST_SERIAL_MSB: assert property (@(posedge clk) disable iff (!rst_n)
    test_out == shf_q[WIDTH-1]); // R6

  AST_CAPTURE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    capture_en && !shift_en |=> shf_q == $past(func_in)); // R7

  AST_UPDATE_XFER: assert property (@(posedge clk) disable iff (!rst_n)
    update_en && !shift_en |=> upd_q == $past(shf_q)); // R8

  AST_SHIFT_KEEPS_UPDATE: assert property (@(posedge clk) disable iff (!rst_n)
    shift_en |=> $stable(upd_q)); // R9

endmodule

bind wbc_cell wbc_cell_chk #(
  .WIDTH(WIDTH), .SAFE_VAL(SAFE_VAL), .ON_CORE_INPUT(ON_CORE_INPUT)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .mode       (mode),
  .shift_en   (shift_en),
  .capture_en (capture_en),
  .update_en  (update_en),
  .test_in    (test_in),
  .test_out   (test_out),
  .func_in    (func_in),
  .func_out   (func_out),
  .shf_q      (shf_q),
  .upd_q      (upd_q)
);

// File: tb/wbc_cell_bench.sv
module wbc_cell_bench;

  localparam int         W    = 4;
  localparam logic [3:0] SAFE = 4'hA;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [1:0]   mode = 2'b00;
  logic         shift_en = 1'b0;
  logic         capture_en = 1'b0;
  logic         update_en = 1'b0;
  logic         test_in = 1'b0;
  logic [W-1:0] func_in = '0;
  logic         test_out;
  logic [W-1:0] func_out;
  logic         test_out_o;
  logic [W-1:0] func_out_o;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #10 clk = ~clk;

  // Cell on a core input
  wbc_cell #(.WIDTH(W), .SAFE_VAL(SAFE), .ON_CORE_INPUT(1'b1)) u_wbc_cell (
    .clk(clk), .rst_n(rst_n), .mode(mode), .shift_en(shift_en),
    .capture_en(capture_en), .update_en(update_en), .test_in(test_in),
    .test_out(test_out), .func_in(func_in), .func_out(func_out)
  );

  // Mirror cell on a core output, same stimulus
  wbc_cell #(.WIDTH(W), .SAFE_VAL(SAFE), .ON_CORE_INPUT(1'b0)) u_wbc_cell_out (
    .clk(clk), .rst_n(rst_n), .mode(mode), .shift_en(shift_en),
    .capture_en(capture_en), .update_en(update_en), .test_in(test_in),
    .test_out(test_out_o), .func_in(func_in), .func_out(func_out_o)
  );

  task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Drive at a falling edge, let one rising edge pass, return at the next falling edge.
  task automatic step(input logic sh, input logic cap, input logic up, input logic ti);
    shift_en = sh; capture_en = cap; update_en = up; test_in = ti;
    @(posedge clk);
    @(negedge clk);
    shift_en = 1'b0; capture_en = 1'b0; update_en = 1'b0;
  endtask

  task automatic load_word(input logic [W-1:0] v);
    for (int i = W - 1; i >= 0; i--) begin
      step(1'b1, 1'b0, 1'b0, v[i]);
      check("R9 func_out steady while shifting", func_out, SAFE);
    end
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    func_in = 4'h3;
    @(negedge clk);
    check("R1 serial out cleared", {3'b0, test_out}, 4'h0);
    mode = 2'b01;
    #1 check("R1 update stage at safe value", func_out, SAFE);
    mode = 2'b11;
    #1 check("R5 safe during reset", func_out, SAFE);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_normal;
    mode = 2'b00;
    func_in = 4'h3;
    #1 check("R2 input cell pass", func_out, 4'h3);
    check("R2 output cell pass", func_out_o, 4'h3);
    func_in = 4'hC;
    #1 check("R2 pass follows input", func_out, 4'hC);
  endtask

  task automatic t_shift_update;
    mode = 2'b01;
    func_in = 4'h1;
    load_word(4'h6);
    check("R6 msb of shifted word on test_out", {3'b0, test_out}, 4'h0);
    check("R3 output cell passes in inward mode", func_out_o, 4'h1);
    step(1'b0, 1'b0, 1'b1, 1'b0);
    check("R3 inward drives updated word", func_out, 4'h6);
    check("R8 update copies shift stage", func_out, 4'h6);
    mode = 2'b10;
    #1 check("R4 output cell drives in outward mode", func_out_o, 4'h6);
    check("R4 input cell passes in outward mode", func_out, 4'h1);
    mode = 2'b11;
    func_in = 4'h5;
    #1 check("R5 input cell safe", func_out, SAFE);
    check("R5 output cell safe", func_out_o, SAFE);
  endtask

  task automatic t_capture;
    logic [W-1:0] got;
    mode = 2'b01;
    func_in = 4'h9;
    step(1'b0, 1'b1, 1'b0, 1'b0);
    check("R9 capture leaves func_out", func_out, 4'h6);
    check("R7 captured msb on test_out", {3'b0, test_out}, 4'h1);
    got = '0;
    for (int i = W - 1; i >= 0; i--) begin
      got[i] = test_out;
      step(1'b1, 1'b0, 1'b0, 1'b0);
    end
    check("R6 serial readback of captured word", got, 4'h9);
    check("R7 captured word read out", got, 4'h9);
    check("R9 readback leaves func_out", func_out, 4'h6);
  endtask

  task automatic t_priority;
    mode = 2'b01;
    func_in = 4'hF;
    step(1'b0, 1'b1, 1'b0, 1'b0);          // shift stage = F
    step(1'b1, 1'b1, 1'b0, 1'b0);          // shift wins: E
    step(1'b0, 1'b0, 1'b1, 1'b0);
    check("R7 shift beats capture", func_out, 4'hE);
    step(1'b1, 1'b0, 1'b1, 1'b1);          // shift stage D, update blocked
    check("R8 update ignored while shifting", func_out, 4'hE);
    step(1'b0, 1'b0, 1'b1, 1'b0);
    check("R8 later update transfers", func_out, 4'hD);
  endtask

  task automatic t_reset_mid;
    mode = 2'b01;
    rst_n = 1'b0;
    #1 check("R1 async reset restores safe update", func_out, SAFE);
    check("R1 async reset clears serial out", {3'b0, test_out}, 4'h0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 stays safe after release", func_out, SAFE);
  endtask

  initial begin
    @(negedge clk);
    t_reset;
    t_normal;
    t_shift_update;
    t_capture;
    t_priority;
    t_reset_mid;
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule